// File: doc/BRIEF.md
# Two-Wire Slave Register Interface

This block is a slave on a two-wire serial bus (clock plus open-drain data line). It serves a six-entry byte register map: four bytes that mirror an external 32-bit seconds counter, one control byte that carries an oscillator-disable flag, and one configuration byte for a battery trickle charger. The block samples the bus lines with a fast system clock, so bus events are seen as edges of synchronized levels. It drives the data line only by asserting an output enable that pulls the line low.

A master opens a transfer with a START, sends the device address with a direction bit, and in a write sends a register address followed by data bytes. A read returns bytes from the current register pointer. The pointer advances after each data byte and wraps from the last entry back to the first. Reads of the counter come from a copy taken when the read address is acknowledged, so a multi-byte read is coherent. Counter writes are collected and handed to the counter as one load. A power-fail input shuts the bus interface out of the registers.

Top module: `twi_reg_slave`

## Requirements
- R1: A fall of SDA while SCL is high is a START and begins a new address phase from any state, including in the middle of a transfer. A rise of SDA while SCL is high is a STOP and returns the slave to idle with SDA released.
- R2: The device address is 7'b1101000: the address byte is 8'hD0 for a write and 8'hD1 for a read (bit 0 = 1 means read). Any other address gets no acknowledge, and SDA stays released for the rest of the transfer until the next START.
- R3: After each byte the slave receives in an addressed transfer, it asserts sda_oe_o (pulls SDA low) from the SCL fall that ends the eighth bit to the SCL fall that ends the ninth bit. sda_oe_o only changes while SCL is low, except when power-fail forces a release.
- R4: In a read, bytes are sent most-significant bit first, one bit per SCL pulse. If the master acknowledges (SDA low on the ninth pulse), the next byte follows. If it does not, the slave releases SDA and sends nothing more until the next START.
- R5: In a write, the byte after the device address loads the register pointer, and a value above 8'h05 loads 8'h00. Each data byte written or read then advances the pointer by one, and 8'h05 is followed by 8'h00.
- R6: Map: 8'h00 to 8'h03 are counter bytes with 8'h00 least significant; 8'h04 is control, where only bit 7 is stored, drives osc_disable_o and reads back (bits 6:0 read 0); 8'h05 is the 8-bit trickle configuration, visible on trickle_cfg_o. Control resets to 8'h00.
- R7: The counter value is copied when a read device address is acknowledged. All counter bytes read in that transfer come from the copy, even if cnt_value_i changes during the read.
- R8: Bytes written to 8'h00 to 8'h02 are held in staging. A write to 8'h03 gives exactly one one-cycle cnt_load_o pulse with cnt_load_data_o = {byte written to 03h, staged 02h, 01h, 00h}.
- R9: Trickle configuration resets to 8'h00. charge_en_o is 1 only when bits 7:4 = 4'b1010, bits 3:2 are 2'b01 or 2'b10, and bits 1:0 are not 2'b00.
- R10: While pwr_fail_i is 1, the slave acknowledges nothing, changes no register, abandons any transfer in progress and releases SDA on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| pwr_fail_i | input | 1 | Supply below threshold: blocks all register access |
| cnt_value_i | input | 32 | Current value of the external counter |
| cnt_load_o | output | 1 | One-cycle load strobe toward the counter |
| cnt_load_data_o | output | 32 | Value to load into the counter |
| osc_disable_o | output | 1 | Control bit 7 (oscillator disable) |
| trickle_cfg_o | output | 8 | Trickle charger configuration byte |
| charge_en_o | output | 1 | Decoded charger enable |

## Verification
A pointer that goes off by one or fails to wrap shows up as a wrong byte at the next read, one byte time later, or as a register that changed when it should not have. A receive or transmit state that is one bit out of step moves the acknowledge window, which the master sees as a missing acknowledge on the same byte. A snapshot taken at the wrong moment returns mixed counter bytes within a single read transfer. A bad staging or load path shows as a missing, repeated or wrong counter load pulse right after the byte at 03h.

// File: rtl/twi_slave_pkg.sv
package twi_slave_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } twi_state_t;

  // Commands from the bus engine to the register bank, each a one-cycle strobe.
  typedef struct packed {
    logic ptr_load;
    logic ptr_inc;
    logic wr_en;
    logic snap_en;
  } bank_cmd_t;

  localparam logic [3:0] CHG_KEY = 4'b1010;

  function automatic logic charge_decode(input logic [7:0] cfg);
    logic key_ok;
    logic diode_ok;
    logic res_ok;
    key_ok   = (cfg[7:4] == CHG_KEY);
    diode_ok = (cfg[3:2] == 2'b01) || (cfg[3:2] == 2'b10);
    res_ok   = (cfg[1:0] != 2'b00);
    return key_ok && diode_ok && res_ok;
  endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl_o,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_det_o,
  output logic stop_det_o
);

  logic [SYNC_STAGES-1:0] scl_pipe_q, scl_pipe_d;
  logic [SYNC_STAGES-1:0] sda_pipe_q, sda_pipe_d;
  logic scl_prev_q, sda_prev_q;
  logic scl_now, sda_now;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      assign scl_pipe_d = scl_i;
      assign sda_pipe_d = sda_i;
    end else begin : g_chain
      assign scl_pipe_d = {scl_pipe_q[SYNC_STAGES-2:0], scl_i};
      assign sda_pipe_d = {sda_pipe_q[SYNC_STAGES-2:0], sda_i};
    end
  endgenerate

  assign scl_now = scl_pipe_q[SYNC_STAGES-1];
  assign sda_now = sda_pipe_q[SYNC_STAGES-1];

  // Reset to the idle bus levels so that no edge is seen when reset ends.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
      scl_prev_q <= scl_now;
      sda_prev_q <= sda_now;
    end
  end

  assign scl_lvl_o   = scl_now;
  assign sda_lvl_o   = sda_now;
  assign scl_rise_o  = scl_now & ~scl_prev_q;
  assign scl_fall_o  = ~scl_now & scl_prev_q;
  assign start_det_o = scl_now & scl_prev_q & sda_prev_q & ~sda_now;
  assign stop_det_o  = scl_now & scl_prev_q & ~sda_prev_q & sda_now;

endmodule

// File: rtl/twi_bus_engine.sv
module twi_bus_engine
  import twi_slave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      scl_lvl_i,
  input  logic      sda_lvl_i,
  input  logic      scl_rise_i,
  input  logic      scl_fall_i,
  input  logic      start_det_i,
  input  logic      stop_det_i,
  input  logic      pwr_fail_i,
  input  logic [7:0] rd_byte_i,
  output bank_cmd_t cmd_o,
  output logic [7:0] byte_o,
  output logic      sda_oe_o
);

  localparam logic [3:0] BITS = 4'd8;

  twi_state_t state_q, state_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d;
  logic [7:0] tx_q, tx_d;
  logic       rw_q, rw_d;
  logic       mack_q, mack_d;
  logic       last_bit_fall;

  assign last_bit_fall = scl_fall_i && (cnt_q == BITS);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    cmd_o   = '0;
    if (pwr_fail_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else if (start_det_i) begin
      state_d = ST_DEV;
      cnt_d   = '0;
    end else if (stop_det_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else begin
      case (state_q)
        ST_DEV, ST_REG, ST_WR: begin
          if (scl_rise_i) begin
            sh_d  = {sh_q[6:0], sda_lvl_i};
            cnt_d = 4'(cnt_q + 4'd1);
          end else if (last_bit_fall) begin
            cnt_d = '0;
            if (state_q == ST_DEV) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                state_d       = ST_DEV_ACK;
                rw_d          = sh_q[0];
                cmd_o.snap_en = sh_q[0];
              end else begin
                state_d = ST_IDLE;
              end
            end else if (state_q == ST_REG) begin
              state_d        = ST_REG_ACK;
              cmd_o.ptr_load = 1'b1;
            end else begin
              state_d       = ST_WR_ACK;
              cmd_o.wr_en   = 1'b1;
              cmd_o.ptr_inc = 1'b1;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall_i) begin
            if (rw_q) begin
              state_d = ST_RD;
              tx_d    = rd_byte_i;
            end else begin
              state_d = ST_REG;
            end
          end
        end
        ST_REG_ACK, ST_WR_ACK: begin
          if (scl_fall_i) state_d = ST_WR;
        end
        ST_RD: begin
          if (scl_rise_i) begin
            cnt_d = 4'(cnt_q + 4'd1);
          end else if (last_bit_fall) begin
            cnt_d         = '0;
            state_d       = ST_RD_ACK;
            mack_d        = 1'b0;
            cmd_o.ptr_inc = 1'b1;
          end else if (scl_fall_i) begin
            tx_d = {tx_q[6:0], 1'b1};
          end
        end
        ST_RD_ACK: begin
          if (scl_rise_i) begin
            mack_d = ~sda_lvl_i;
          end else if (scl_fall_i) begin
            if (mack_q) begin
              state_d = ST_RD;
              tx_d    = rd_byte_i;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '1;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
    end
  end

  assign byte_o   = sh_q;
  assign sda_oe_o = (state_q == ST_DEV_ACK) || (state_q == ST_REG_ACK) ||
                    (state_q == ST_WR_ACK) || ((state_q == ST_RD) && !tx_q[7]);

  AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det_i && !pwr_fail_i) |=> (state_q == ST_DEV && cnt_q == 4'd0)); // R1

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe_o) && !$past(pwr_fail_i)) |-> !scl_lvl_i); // R3

  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_ACK && scl_fall_i && !mack_q && !start_det_i && !pwr_fail_i)
    |=> (!sda_oe_o && state_q == ST_IDLE)); // R4

  AST_PWR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail_i |=> !sda_oe_o); // R10

  AST_PWR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail_i |-> (cmd_o == '0)); // R10

endmodule

// File: rtl/twi_reg_bank.sv
module twi_reg_bank
  import twi_slave_pkg::*;
#(
  parameter int         CNT_W       = 32,
  parameter logic [7:0] TRICKLE_RST = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bank_cmd_t        cmd_i,
  input  logic [7:0]       byte_i,
  input  logic [CNT_W-1:0] cnt_value_i,
  output logic [7:0]       rd_byte_o,
  output logic             cnt_load_o,
  output logic [CNT_W-1:0] cnt_load_data_o,
  output logic             ctrl_bit_o,
  output logic [7:0]       trickle_o
);

  localparam int CNT_BYTES = CNT_W / 8;
  localparam int LAST      = CNT_BYTES + 1;
  localparam int PW        = $clog2(LAST + 1);
  localparam int STW       = CNT_W - 8;
  localparam logic [PW-1:0] CTRL_P  = PW'(CNT_BYTES);
  localparam logic [PW-1:0] LAST_P  = PW'(LAST);
  localparam logic [PW-1:0] TOPCNT_P = PW'(CNT_BYTES - 1);

  logic [PW-1:0]    ptr_q, ptr_d;
  logic [CNT_W-1:0] snap_q, snap_d;
  logic [STW-1:0]   stage_q, stage_d;
  logic             ctrl_q, ctrl_d;
  logic [7:0]       trk_q, trk_d;
  logic             load_q, load_d;
  logic [CNT_W-1:0] ldat_q, ldat_d;
  logic             wr_top;

  // Pointer: explicit load wins, otherwise advance with wrap.
  always_comb begin
    ptr_d = ptr_q;
    if (cmd_i.ptr_load) begin
      if (byte_i > 8'(LAST)) ptr_d = '0;
      else                   ptr_d = byte_i[PW-1:0];
    end else if (cmd_i.ptr_inc) begin
      if (ptr_q == LAST_P) ptr_d = '0;
      else                 ptr_d = PW'(ptr_q + 1'b1);
    end
  end

  assign snap_d = cmd_i.snap_en ? cnt_value_i : snap_q;

  generate
    for (genvar g = 0; g < CNT_BYTES - 1; g++) begin : g_stage
      assign stage_d[g*8 +: 8] = (cmd_i.wr_en && ptr_q == PW'(g)) ? byte_i : stage_q[g*8 +: 8];
    end
  endgenerate

  assign wr_top = cmd_i.wr_en && (ptr_q == TOPCNT_P);
  assign load_d = wr_top;
  assign ldat_d = wr_top ? {byte_i, stage_q} : ldat_q;
  assign ctrl_d = (cmd_i.wr_en && ptr_q == CTRL_P) ? byte_i[7] : ctrl_q;
  assign trk_d  = (cmd_i.wr_en && ptr_q == LAST_P) ? byte_i : trk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      snap_q  <= '0;
      stage_q <= '0;
      ctrl_q  <= 1'b0;
      trk_q   <= TRICKLE_RST;
      load_q  <= 1'b0;
      ldat_q  <= '0;
    end else begin
      ptr_q   <= ptr_d;
      snap_q  <= snap_d;
      stage_q <= stage_d;
      ctrl_q  <= ctrl_d;
      trk_q   <= trk_d;
      load_q  <= load_d;
      ldat_q  <= ldat_d;
    end
  end

  always_comb begin
    rd_byte_o = 8'h00;
    for (int i = 0; i < CNT_BYTES; i++) begin
      if (ptr_q == PW'(i)) rd_byte_o = snap_q[i*8 +: 8];
    end
    if (ptr_q == CTRL_P) rd_byte_o = {ctrl_q, 7'b0};
    if (ptr_q == LAST_P) rd_byte_o = trk_q;
  end

  assign cnt_load_o      = load_q;
  assign cnt_load_data_o = ldat_q;
  assign ctrl_bit_o      = ctrl_q;
  assign trickle_o       = trk_q;

  AST_PTR_IN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST_P); // R5

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i.ptr_inc && !cmd_i.ptr_load && ptr_q == LAST_P) |=> (ptr_q == '0)); // R5

  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load_o |=> !cnt_load_o); // R8

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_i.snap_en |=> $stable(snap_q)); // R7

endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave
  import twi_slave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         CNT_W       = 32,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] TRICKLE_RST = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic             pwr_fail_i,
  input  logic [CNT_W-1:0] cnt_value_i,
  output logic             cnt_load_o,
  output logic [CNT_W-1:0] cnt_load_data_o,
  output logic             osc_disable_o,
  output logic [7:0]       trickle_cfg_o,
  output logic             charge_en_o
);

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  // Reset asserts at once and is released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  bank_cmd_t  cmd;
  logic [7:0] rx_byte, rd_byte;

  twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_lvl_o  (scl_lvl),
    .sda_lvl_o  (sda_lvl),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_det_o(start_det),
    .stop_det_o (stop_det)
  );

  twi_bus_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .scl_lvl_i  (scl_lvl),
    .sda_lvl_i  (sda_lvl),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_det_i(start_det),
    .stop_det_i (stop_det),
    .pwr_fail_i (pwr_fail_i),
    .rd_byte_i  (rd_byte),
    .cmd_o      (cmd),
    .byte_o     (rx_byte),
    .sda_oe_o   (sda_oe_o)
  );

  twi_reg_bank #(.CNT_W(CNT_W), .TRICKLE_RST(TRICKLE_RST)) u_bank (
    .clk            (clk),
    .rst_n          (rst_n_s),
    .cmd_i          (cmd),
    .byte_i         (rx_byte),
    .cnt_value_i    (cnt_value_i),
    .rd_byte_o      (rd_byte),
    .cnt_load_o     (cnt_load_o),
    .cnt_load_data_o(cnt_load_data_o),
    .ctrl_bit_o     (osc_disable_o),
    .trickle_o      (trickle_cfg_o)
  );

  assign charge_en_o = charge_decode(trickle_cfg_o);

  AST_CHARGE_KEY: assert property (@(posedge clk) disable iff (!rst_n_s)
    charge_en_o |-> (trickle_cfg_o[7:4] == 4'b1010 && trickle_cfg_o[1:0] != 2'b00)); // R9

  AST_PWR_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($past(pwr_fail_i) && pwr_fail_i) |-> ($stable(trickle_cfg_o) && $stable(osc_disable_o))); // R10

endmodule

// File: tb/twi_reg_slave_tb.sv
module twi_reg_slave_tb;

  localparam int H = 20;

  logic        clk, rst_n;
  logic        scl_m, sda_m;
  logic        sda_line;
  logic        sda_oe;
  logic        pwr_fail;
  logic [31:0] cnt_value;
  logic        cnt_load;
  logic [31:0] cnt_load_data;
  logic        osc_dis;
  logic [7:0]  trk_cfg;
  logic        chg_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0]  exp_rd_q[$];
  string       exp_tag_q[$];
  logic [31:0] exp_ld_q[$];
  logic [7:0]  rd_val;
  event        rd_ev;

  assign sda_line = sda_m & ~sda_oe;

  twi_reg_slave u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .scl_i          (scl_m),
    .sda_i          (sda_line),
    .sda_oe_o       (sda_oe),
    .pwr_fail_i     (pwr_fail),
    .cnt_value_i    (cnt_value),
    .cnt_load_o     (cnt_load),
    .cnt_load_data_o(cnt_load_data),
    .osc_disable_o  (osc_dis),
    .trickle_cfg_o  (trk_cfg),
    .charge_en_o    (chg_en)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(H/4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(H);
      scl_m = 1'b1; tick(H);
      scl_m = 1'b0; tick(H/4);
    end
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H/2);
    ack = (sda_line == 1'b0);
    tick(H/2);
    scl_m = 1'b0; tick(H/4);
  endtask

  task automatic read_byte(input logic master_ack, output logic [7:0] b);
    sda_m = 1'b1;
    b = 8'h00;
    tick(H);
    for (int i = 0; i < 8; i++) begin
      scl_m = 1'b1; tick(H/2);
      b = {b[6:0], sda_line};
      tick(H/2);
      scl_m = 1'b0; tick(H);
    end
    sda_m = ~master_ack; tick(H/2);
    scl_m = 1'b1; tick(H);
    scl_m = 1'b0; tick(H/2);
    sda_m = 1'b1; tick(H/2);
    rd_val = b;
    -> rd_ev;
  endtask

  // Driver side: one register write transaction.
  task automatic reg_write(input logic [7:0] ptr, input logic [7:0] val, input string tag);
    logic a;
    bus_start();
    write_byte(8'hD0, a); check({tag, " R3 dev ack"}, a, 1);
    write_byte(ptr, a);   check({tag, " R3 ptr ack"}, a, 1);
    write_byte(val, a);   check({tag, " R3 data ack"}, a, 1);
    bus_stop();
  endtask

  task automatic expect_rd(input logic [7:0] v, input string tag);
    exp_rd_q.push_back(v);
    exp_tag_q.push_back(tag);
  endtask

  // Monitor: compare each read byte with the oldest expected item.
  initial begin
    forever begin
      @(rd_ev);
      if (exp_rd_q.size() == 0) begin
        check("R4 unexpected read byte", {24'h0, rd_val}, 32'hFFFF_FFFF);
      end else begin
        check(exp_tag_q.pop_front(), {24'h0, rd_val}, {24'h0, exp_rd_q.pop_front()});
      end
    end
  end

  // Monitor: counter load pulses against queued expectations.
  always @(negedge clk) begin
    if (rst_n && cnt_load) begin
      if (exp_ld_q.size() == 0) check("R8 unexpected counter load", cnt_load_data, 32'hFFFF_FFFF);
      else check("R8 counter load data", cnt_load_data, exp_ld_q.pop_front());
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] b;
    scl_m = 1'b1; sda_m = 1'b1; pwr_fail = 1'b0; cnt_value = 32'hDEADBEEF;
    rst_n = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(10);

    check("R9 reset trickle", trk_cfg, 8'h00);
    check("R9 reset charge_en", chg_en, 0);
    check("R6 reset control", osc_dis, 0);
    check("R3 reset sda_oe", sda_oe, 0);
    check("R8 reset load", cnt_load, 0);

    // Trickle decode (R9)
    reg_write(8'h05, 8'hA5, "R9 A5");
    check("R9 A5 cfg", trk_cfg, 8'hA5);
    check("R9 A5 enabled", chg_en, 1);
    reg_write(8'h05, 8'hA4, "R9 A4");
    check("R9 A4 res 00 disabled", chg_en, 0);
    reg_write(8'h05, 8'hB5, "R9 B5");
    check("R9 B5 bad key disabled", chg_en, 0);
    reg_write(8'h05, 8'hAD, "R9 AD");
    check("R9 AD diode 11 disabled", chg_en, 0);
    reg_write(8'h05, 8'hA6, "R9 A6");
    check("R9 A6 enabled", chg_en, 1);

    // Sequential write from 04h with wrap and counter load (R5, R6, R8)
    exp_ld_q.push_back(32'h44332211);
    bus_start();
    write_byte(8'hD0, a); check("R2 dev D0 ack", a, 1);
    write_byte(8'h04, a); check("R5 ptr 04 ack", a, 1);
    write_byte(8'hFF, a); check("R3 ctrl ack", a, 1);
    write_byte(8'hA9, a); check("R3 trickle ack", a, 1);
    write_byte(8'h11, a);
    write_byte(8'h22, a);
    write_byte(8'h33, a);
    check("R8 no load before 03h", cnt_load, 0);
    write_byte(8'h44, a); check("R5 wrapped 03h ack", a, 1);
    bus_stop();
    check("R6 osc_disable set", osc_dis, 1);
    check("R5 trickle via seq", trk_cfg, 8'hA9);
    check("R8 one load consumed", exp_ld_q.size(), 0);
    check("R1 released after stop", sda_oe, 0);

    // Read with repeated START, snapshot coherence and wrap (R1, R4, R6, R7)
    bus_start();
    write_byte(8'hD0, a);
    write_byte(8'h00, a);
    bus_start();
    write_byte(8'hD1, a); check("R2 dev D1 ack", a, 1);
    expect_rd(8'hEF, "R6 byte 00h lsb");
    read_byte(1'b1, b);
    cnt_value = 32'h12345678;
    expect_rd(8'hBE, "R7 snapshot byte 01h");
    read_byte(1'b1, b);
    expect_rd(8'hAD, "R7 snapshot byte 02h");
    read_byte(1'b1, b);
    expect_rd(8'hDE, "R7 snapshot byte 03h");
    read_byte(1'b1, b);
    expect_rd(8'h80, "R6 control reads bit7 only");
    read_byte(1'b1, b);
    expect_rd(8'hA9, "R6 trickle readback");
    read_byte(1'b1, b);
    expect_rd(8'hEF, "R5 read wrap to 00h");
    read_byte(1'b0, b);
    // After NACK the slave must not drive a further bit (R4)
    tick(H);
    scl_m = 1'b1; tick(H/2);
    check("R4 released after nack", sda_line, 1);
    tick(H/2);
    scl_m = 1'b0; tick(H);
    bus_stop();

    // Pointer above 05h loads 00h; fresh snapshot (R5, R7)
    bus_start();
    write_byte(8'hD0, a);
    write_byte(8'h07, a); check("R5 ptr 07 ack", a, 1);
    bus_start();
    write_byte(8'hD1, a);
    expect_rd(8'h78, "R5 ptr 07 maps to 00h");
    read_byte(1'b0, b);
    bus_stop();
    // Pointer continues at 01h in a new read
    bus_start();
    write_byte(8'hD1, a);
    expect_rd(8'h56, "R5 pointer persists 01h");
    read_byte(1'b0, b);
    bus_stop();

    // Address mismatch (R2)
    bus_start();
    write_byte(8'hA0, a); check("R2 mismatch no ack", a, 0);
    write_byte(8'h05, a); check("R2 ignored until start", a, 0);
    write_byte(8'h00, a);
    bus_stop();
    check("R2 mismatch no write", trk_cfg, 8'hA9);

    // Power fail (R10)
    pwr_fail = 1'b1;
    tick(4);
    bus_start();
    write_byte(8'hD0, a); check("R10 no ack under pwr_fail", a, 0);
    write_byte(8'h05, a);
    write_byte(8'h00, a);
    bus_stop();
    check("R10 trickle unchanged", trk_cfg, 8'hA9);
    pwr_fail = 1'b0;
    tick(4);
    bus_start();
    write_byte(8'hD0, a); check("R10 ack after recovery", a, 1);
    write_byte(8'h05, a);
    pwr_fail = 1'b1;
    write_byte(8'h00, a); check("R10 mid-transfer no ack", a, 0);
    check("R10 sda released", sda_oe, 0);
    bus_stop();
    check("R10 mid-transfer no write", trk_cfg, 8'hA9);
    pwr_fail = 1'b0;
    tick(H);

    check("R7 all reads consumed", exp_rd_q.size(), 0);
    check("R8 no extra loads", exp_ld_q.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule